// File: doc/BRIEF.md
# Measurement-Conditioned Qubit/Qudit Reset Sequencer

This block returns a qubit or a d-level qudit to its ground level by acting on a readout result, instead of waiting for thermal decay. A reset request arms it. It then waits for a discriminated readout (a valid strobe plus a level index). After a fixed, programmable decision delay it either finishes at once, when the readout shows the ground level, or it starts a chain of single-transition π-pulse requests to the pulse generator. Each request lowers the population by one level. The generator acknowledges each pulse with a done handshake, and the next request goes out only after that handshake.

The decision delay is the same for every readout value, so the time from readout to the first action has no jitter. A programmable watchdog guards each pulse. If no acknowledgement arrives within the window, the sequence is abandoned and an error flag is raised. The flag stays high until the next accepted request. Both the delay and the window are taken from configuration inputs when a request is accepted, and they stay fixed for the rest of that run.

Top module: `qreset_ctrl`

## Requirements
- R1: After reset, `busy_o`, `ptrig_o`, `done_o` and `err_o` are all low.
- R2: `start_i` sampled high while idle sets `busy_o` high from the next cycle. A readout strobe sampled while idle has no effect: `busy_o` and `ptrig_o` stay low.
- R3: The first trigger, or the done strobe for a ground readout, appears exactly D+1 cycles after the clock edge that samples `rd_valid_i`. D is the value of `dly_cfg_i` captured when the request was accepted. This latency does not depend on the readout value, and D=0 gives 1 cycle.
- R4: A readout index of 0 issues no trigger and produces the done strobe.
- R5: A readout index k>0 issues exactly k triggers. Their `ptgt_o` values are k, k-1, ..., 1, in that order, where value j names the transition from level j down to level j-1.
- R6: `ptrig_o` is high for one cycle per pulse. No further trigger is issued until `pdone_i` has been sampled high. The next trigger, or the done strobe after the last pulse, follows exactly one cycle after that sample.
- R7: A readout index of LEVELS or more (LEVELS=5 by default, 3-bit index) is treated as LEVELS-1, so index 7 produces targets 4, 3, 2, 1.
- R8: After a trigger, `pdone_i` is accepted during the first max(T,1) waiting cycles, where T is `tmo_cfg_i` captured at the request. If no acknowledgement arrives in that window, the run aborts: `err_o` rises, `busy_o` falls and no done strobe is issued. The next accepted request clears `err_o`.
- R9: `start_i` while busy is ignored: the run is not restarted and the captured delay and timeout are not reloaded.
- R10: `done_o` is a one-cycle strobe, and `busy_o` is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Reset request |
| dly_cfg_i | input | DLY_W | Decision delay in cycles, captured at request |
| tmo_cfg_i | input | TMO_W | Pulse acknowledgement window in cycles, captured at request |
| rd_valid_i | input | 1 | Readout result strobe |
| rd_state_i | input | IDX_W | Discriminated level index |
| pdone_i | input | 1 | Pulse completed handshake |
| ptrig_o | output | 1 | π-pulse request, one cycle |
| ptgt_o | output | IDX_W | Upper level of the requested transition |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Reset completed strobe |
| err_o | output | 1 | Last run aborted by timeout |

## Verification
The bench measures the readout-to-action latency for ground and excited results at the same delay, and again at zero delay. A design whose decision path depended on the result, or that was off by one in its delay counter, would show a different cycle count. Cascades from several levels, including an out-of-range index, check the descending target order. A wrong step or a missing clamp would produce a target outside the level set or the wrong number of pulses. The acknowledgement window is probed at its last accepted cycle and one cycle past it; an off-by-one watchdog would either abort a valid run or hang on a lost pulse. Requests during a run that carry different settings would reveal a design that reloads its configuration or restarts mid-sequence.

// File: rtl/qreset_pkg.sv
package qreset_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WRD   = 3'd1,
    ST_DECIDE = 3'd2,
    ST_FIRE  = 3'd3,
    ST_WPD   = 3'd4,
    ST_FIN   = 3'd5
  } rst_state_e;

  function automatic int idx_bits(input int n);
    return (n > 2) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/qreset_dcnt.sv
module qreset_dcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         en_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = val_i;
    end else if (en_i && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i || en_i) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/qreset_wdog.sv
module qreset_wdog #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         arm_i,
  input  logic         en_i,
  input  logic [W-1:0] lim_i,
  output logic         exp_o
);

  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] VMAX = '1;

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (arm_i) begin
      cnt_d = ONE;
    end else if (en_i && (cnt_q != VMAX)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (arm_i || en_i) begin
      cnt_q <= cnt_d;
    end
  end

  assign exp_o = (cnt_q >= lim_i);

endmodule

// File: rtl/qreset_lvl.sv
module qreset_lvl #(
  parameter int LEVELS = 5,
  localparam int IDX_W = qreset_pkg::idx_bits(LEVELS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             dec_i,
  output logic [IDX_W-1:0] lvl_o,
  output logic             zero_o,
  output logic             last_o
);

  localparam logic [IDX_W-1:0] TOP = IDX_W'(LEVELS - 1);

  logic [IDX_W-1:0] lvl_q;
  logic [IDX_W-1:0] lvl_d;
  logic [IDX_W-1:0] idx_clamped;

  always_comb begin
    idx_clamped = (idx_i > TOP) ? TOP : idx_i;
  end

  always_comb begin
    lvl_d = lvl_q;
    if (cap_i) begin
      lvl_d = idx_clamped;
    end else if (dec_i && (lvl_q != '0)) begin
      lvl_d = lvl_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
    end else if (cap_i || dec_i) begin
      lvl_q <= lvl_d;
    end
  end

  assign lvl_o  = lvl_q;
  assign zero_o = (lvl_q == '0);
  assign last_o = (lvl_q == IDX_W'(1));

endmodule

// File: rtl/qreset_ctrl.sv
module qreset_ctrl #(
  parameter int LEVELS = 5,
  parameter int DLY_W  = 8,
  parameter int TMO_W  = 8,
  localparam int IDX_W = qreset_pkg::idx_bits(LEVELS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DLY_W-1:0] dly_cfg_i,
  input  logic [TMO_W-1:0] tmo_cfg_i,
  input  logic             rd_valid_i,
  input  logic [IDX_W-1:0] rd_state_i,
  input  logic             pdone_i,
  output logic             ptrig_o,
  output logic [IDX_W-1:0] ptgt_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);

  import qreset_pkg::*;

  rst_state_e st_q;
  rst_state_e st_d;

  logic [DLY_W-1:0] dly_q;
  logic [TMO_W-1:0] tmo_q;
  logic             err_q;
  logic             err_d;

  logic accept;
  logic capture;
  logic dly_zero;
  logic wd_arm;
  logic wd_en;
  logic wd_exp;
  logic lvl_dec;
  logic lvl_zero;
  logic lvl_last;
  logic [IDX_W-1:0] lvl;
  logic abort;

  assign accept  = (st_q == ST_IDLE) && start_i;
  assign capture = (st_q == ST_WRD) && rd_valid_i;
  assign wd_arm  = (st_q == ST_FIRE);
  assign wd_en   = (st_q == ST_WPD) && !pdone_i;
  assign lvl_dec = (st_q == ST_WPD) && pdone_i;
  assign abort   = (st_q == ST_WPD) && !pdone_i && wd_exp;

  // configuration captured once per accepted request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q <= '0;
      tmo_q <= '0;
    end else if (accept) begin
      dly_q <= dly_cfg_i;
      tmo_q <= tmo_cfg_i;
    end
  end

  qreset_dcnt #(.W(DLY_W)) u_dcnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (capture),
    .val_i  (dly_q),
    .en_i   (st_q == ST_DECIDE),
    .zero_o (dly_zero)
  );

  qreset_wdog #(.W(TMO_W)) u_wdog (
    .clk   (clk),
    .rst_n (rst_n),
    .arm_i (wd_arm),
    .en_i  (wd_en),
    .lim_i (tmo_q),
    .exp_o (wd_exp)
  );

  qreset_lvl #(.LEVELS(LEVELS)) u_lvl (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_i  (capture),
    .idx_i  (rd_state_i),
    .dec_i  (lvl_dec),
    .lvl_o  (lvl),
    .zero_o (lvl_zero),
    .last_o (lvl_last)
  );

  // next-state logic
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (start_i) st_d = ST_WRD;
      ST_WRD:    if (rd_valid_i) st_d = ST_DECIDE;
      ST_DECIDE: if (dly_zero) st_d = lvl_zero ? ST_FIN : ST_FIRE;
      ST_FIRE:   st_d = ST_WPD;
      ST_WPD: begin
        if (pdone_i) begin
          st_d = lvl_last ? ST_FIN : ST_FIRE;
        end else if (wd_exp) begin
          st_d = ST_IDLE;
        end
      end
      ST_FIN:    st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    err_d = err_q;
    if (accept) begin
      err_d = 1'b0;
    end else if (abort) begin
      err_d = 1'b1;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
    end
  end

  assign ptrig_o = (st_q == ST_FIRE);
  assign ptgt_o  = lvl;
  assign busy_o  = (st_q != ST_IDLE);
  assign done_o  = (st_q == ST_FIN);
  assign err_o   = err_q;

endmodule

// File: rtl/qreset_ctrl_chk.sv
module qreset_ctrl_chk #(
  parameter int LEVELS = 5,
  localparam int IDX_W = qreset_pkg::idx_bits(LEVELS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             ptrig_o,
  input logic [IDX_W-1:0] ptgt_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             err_o
);

  logic [IDX_W-1:0] prev_tgt;
  logic             have_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_tgt  <= '0;
      have_prev <= 1'b0;
    end else if (!busy_o) begin
      have_prev <= 1'b0;
    end else if (ptrig_o) begin
      prev_tgt  <= ptgt_o;
      have_prev <= 1'b1;
    end
  end

  a_r1_trig_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ptrig_o |-> busy_o);

  a_r2_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  a_r5_tgt_range: assert property (@(posedge clk) disable iff (!rst_n)
    ptrig_o |-> (ptgt_o != '0) && (ptgt_o <= IDX_W'(LEVELS - 1)));

  a_r5_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (ptrig_o && have_prev) |-> (ptgt_o == IDX_W'(prev_tgt - 1'b1)));

  a_r6_trig_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ptrig_o |=> !ptrig_o);

  a_r8_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> (!busy_o && !done_o));

  a_r10_done_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

endmodule

bind qreset_ctrl qreset_ctrl_chk #(.LEVELS(LEVELS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .ptrig_o (ptrig_o),
  .ptgt_o  (ptgt_o),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .err_o   (err_o)
);

// File: tb/sim_qreset_ctrl.sv
module sim_qreset_ctrl;

  localparam int LEVELS = 5;
  localparam int DLY_W  = 8;
  localparam int TMO_W  = 8;
  localparam int IDX_W  = 3;

  logic             clk;
  logic             rst_n;
  logic             start_i;
  logic [DLY_W-1:0] dly_cfg_i;
  logic [TMO_W-1:0] tmo_cfg_i;
  logic             rd_valid_i;
  logic [IDX_W-1:0] rd_state_i;
  logic             pdone_i;
  logic             ptrig_o;
  logic [IDX_W-1:0] ptgt_o;
  logic             busy_o;
  logic             done_o;
  logic             err_o;

  int nchk;
  int nbad;
  bit fin;

  qreset_ctrl #(.LEVELS(LEVELS), .DLY_W(DLY_W), .TMO_W(TMO_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dly_cfg_i(dly_cfg_i),
    .tmo_cfg_i(tmo_cfg_i), .rd_valid_i(rd_valid_i), .rd_state_i(rd_state_i),
    .pdone_i(pdone_i), .ptrig_o(ptrig_o), .ptgt_o(ptgt_o), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start_i = 1'b0; dly_cfg_i = '0; tmo_cfg_i = '0;
    rd_valid_i = 1'b0; rd_state_i = '0; pdone_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !ptrig_o && !done_o && !err_o, "R1 reset outputs",
        {busy_o, ptrig_o, done_o, err_o}, 0);
  endtask

  task automatic arm(input int d, input int t);
    start_i = 1'b1; dly_cfg_i = DLY_W'(d); tmo_cfg_i = TMO_W'(t);
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o, "R2 busy after start", busy_o, 1);
  endtask

  // drive a readout and return the negedge count until trigger or done
  task automatic readout(input int k, output int lat);
    lat = -1;
    rd_valid_i = 1'b1; rd_state_i = IDX_W'(k);
    for (int c = 1; c <= 300; c++) begin
      @(negedge clk);
      rd_valid_i = 1'b0;
      if (ptrig_o || done_o) begin
        lat = c;
        break;
      end
    end
  endtask

  task automatic serve(input int lvl, input int gap);
    for (int j = lvl; j >= 1; j--) begin
      chk(ptrig_o && (ptgt_o == IDX_W'(j)), "R5 trigger target", int'(ptgt_o), j);
      for (int g = 1; g < gap; g++) begin
        @(negedge clk);
        chk(!ptrig_o && !done_o && busy_o, "R6 hold until pulse done", ptrig_o, 0);
      end
      @(negedge clk);
      pdone_i = 1'b1;
      @(negedge clk);
      pdone_i = 1'b0;
    end
    chk(done_o && !ptrig_o, "R6 done after last pulse", done_o, 1);
  endtask

  task automatic run_full(input int k, input int d, input int t, input int gap);
    int lat;
    int lvl;
    lvl = (k > LEVELS - 1) ? LEVELS - 1 : k;
    arm(d, t);
    @(negedge clk);
    readout(k, lat);
    chk(lat == d + 2, "R3 decision latency", lat, d + 2);
    if (lvl == 0) begin
      chk(done_o && !ptrig_o, "R4 ground gives done, no pulse", ptrig_o, 0);
    end else begin
      serve(lvl, gap);
    end
    @(negedge clk);
    chk(!done_o && !busy_o, "R10 done single cycle then idle", {done_o, busy_o}, 0);
  endtask

  task automatic t_idle_readout();
    rd_valid_i = 1'b1; rd_state_i = 3'd2;
    @(negedge clk);
    rd_valid_i = 1'b0;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      chk(!busy_o && !ptrig_o && !done_o, "R2 readout ignored when idle", busy_o, 0);
    end
  endtask

  task automatic t_timeout();
    int lat;
    arm(2, 4);
    readout(1, lat);
    chk(lat == 4, "R3 latency in timeout run", lat, 4);
    for (int c = 1; c <= 4; c++) begin
      @(negedge clk);
      chk(busy_o && !err_o, "R8 still waiting inside window", err_o, 0);
    end
    @(negedge clk);
    chk(err_o && !busy_o && !done_o, "R8 abort after window", {err_o, busy_o, done_o}, 4);
    repeat (3) @(negedge clk);
    chk(err_o && !done_o, "R8 error held, no done", err_o, 1);
    // last accepted cycle of the window; also clears the error
    arm(1, 4);
    chk(!err_o, "R8 error cleared by new request", err_o, 0);
    readout(2, lat);
    chk(lat == 3, "R3 latency d=1", lat, 3);
    serve(2, 4);
    @(negedge clk);
    chk(!err_o && !busy_o, "R8 window edge accepted", err_o, 0);
  endtask

  task automatic t_start_busy();
    int lat;
    arm(3, 2);
    start_i = 1'b1; dly_cfg_i = 8'd9; tmo_cfg_i = 8'd1;
    @(negedge clk);
    start_i = 1'b0;
    readout(3, lat);
    chk(lat == 5, "R9 delay not reloaded", lat, 5);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o && !ptrig_o && !done_o, "R9 no restart mid cascade", ptrig_o, 0);
    // gap 2 would exceed window 1 if the timeout had been reloaded
    pdone_i = 1'b1;
    @(negedge clk);
    pdone_i = 1'b0;
    serve(2, 2);
    @(negedge clk);
    chk(!busy_o && !err_o, "R9 run completes with captured timeout", err_o, 0);
  endtask

  initial begin
    nchk = 0; nbad = 0; fin = 1'b0;
    do_reset();
    t_idle_readout();
    run_full(0, 5, 8, 1);   // ground readout
    run_full(2, 5, 8, 3);   // same delay, excited
    run_full(0, 0, 8, 1);   // zero delay
    run_full(1, 0, 8, 1);
    run_full(4, 3, 8, 2);   // top level
    run_full(7, 2, 8, 1);   // R7 clamp: 7 -> 4 pulses
    run_full(6, 1, 6, 6);   // R7 clamp, gap at window edge
    t_timeout();
    t_start_busy();
    fin = 1'b1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!fin) begin
      nchk++;
      nbad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

endmodule